// File: doc/BRIEF.md
# USB Device Endpoint Transfer Controller

This block is the control and transfer-tracking logic of one endpoint in a full-speed USB device. Software programs its settings through a small register write port. The settings are: active, transfer type, maximum packet size, transmit FIFO number, data toggle, frame parity, forced NAK, forced STALL and CRC-ignore (snoop). Software also programs the remaining byte count and packet count, then sets enable.

The protocol engine hands each host token to the block over a valid/ready token stream. With the token come the FIFO status, the received data PID, the CRC result and the length of the received data. The block answers with one response on a valid/ready response stream. The response names the handshake or data PID to send and, for data, the packet length. A `tok_ready` that is low back-pressures the engine. `tok_ready` is low while a response is waiting to be accepted, and while an IN data packet waits for the host handshake. A response stays stable until `resp_ready` accepts it.

Each packet that completes lowers the byte and packet counts. A transfer ends on the last packet or on a short packet. A disable request takes effect at the next gap between packets. In both cases the block clears enable and raises a one-cycle flag.

Top module: `usb_ep_xfer_ctrl`

## Requirements
- R1: After reset, enable, the byte count, the packet count, the toggle, `resp_valid`, `xfer_done` and `ep_disabled` are 0, and `tok_ready` is 1.
- R2: A write with `wr_sel`=0 loads the control fields. The bit positions are: [0] enable set, [1] disable request, [2] active, [4:3] type (0 isochronous, 1 bulk, 2 interrupt, 3 bulk), [5] toggle value, [6] toggle load strobe, [7] odd-frame select, [8] forced NAK, [9] forced STALL, [10] snoop, [14:11] TX FIFO number, [26:16] max packet size. The FIFO number and max packet size appear on `tx_fifo_num` and `max_pkt`.
- R3: A token to an inactive endpoint gets response NONE and changes no count. An OUT token with a bad CRC gets NONE and changes no count, unless snoop is set, in which case the data is handled as if its CRC were good.
- R4: When the response is not already NONE by R3, forced STALL gives STALL and takes priority over forced NAK and over every other rule.
- R5: Forced NAK gives NAK. A bulk or interrupt endpoint that is not enabled, or whose FIFO is not ready, also answers NAK.
- R6: An isochronous endpoint moves a packet only when it is enabled, the FIFO is ready and `frame_odd` equals the odd-frame select. IN then sends DATA0. An isochronous endpoint never answers ACK and never changes the toggle.
- R7: A bulk or interrupt IN token sends DATA0 or DATA1 to match the toggle, with length min(max packet size, remaining bytes). The counts update only when `hs_valid` arrives with `hs_ack`=1. `hs_ack`=0 leaves them unchanged.
- R8: A bulk or interrupt OUT token answers ACK. Data whose PID matches the toggle (`rx_data1`=toggle) is committed, and data whose PID does not match is acknowledged but dropped. Each committed bulk or interrupt packet flips the toggle. A toggle load whose written type is isochronous is ignored.
- R9: A write with `wr_sel`=1 loads bytes from [18:0] and packets from [28:19] only while enable is 0. While the endpoint is enabled, the counts change only through traffic.
- R10: A committed packet subtracts its length from the byte count, saturating at 0, and subtracts one from the packet count. If the packet count reaches 0 or the packet is shorter than max packet size, enable clears and `xfer_done` pulses for one cycle.
- R11: A disable request while enabled clears enable one cycle after the write, when no IN handshake is pending, and pulses `ep_disabled`. A disable request while not enabled is dropped.
- R12: Response codes are 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA0, 5 DATA1. Each accepted token yields exactly one response in the next cycle. The response holds until `resp_ready`, and `tok_ready` is 0 while a response or an IN handshake is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 control register, 1 transfer size register |
| wr_data | input | 32 | Write data |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Block can take a token |
| tok_is_in | input | 1 | 1 IN token, 0 OUT token |
| rx_data1 | input | 1 | Received data PID is DATA1 |
| rx_crc_ok | input | 1 | Received data CRC good |
| rx_len | input | LEN_W | Received data length in bytes |
| fifo_ok | input | 1 | FIFO has data (IN) or space (OUT) |
| frame_odd | input | 1 | Current frame number is odd |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Engine takes the response |
| resp_code | output | 3 | Handshake or data PID code |
| resp_len | output | LEN_W | Data packet length |
| hs_valid | input | 1 | Host handshake outcome for a pending IN packet |
| hs_ack | input | 1 | 1 host ACK, 0 no ACK |
| ep_enabled | output | 1 | Endpoint enable state |
| xfer_bytes | output | BYTES_W | Remaining byte count |
| xfer_pkts | output | PKT_W | Remaining packet count |
| data_toggle | output | 1 | Current DATA0/DATA1 toggle |
| tx_fifo_num | output | 4 | Programmed TX FIFO number |
| max_pkt | output | 11 | Programmed max packet size |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| ep_disabled | output | 1 | One-cycle endpoint-disabled pulse |

## Verification
The bench aims at the priority chain first. A STALL that loses to NAK, or a bad CRC that still draws a handshake, shows up as a wrong response code. For isochronous endpoints it checks parity mismatches and toggle loads, which a faulty design would answer with ACK or let flip the toggle. It sends duplicate OUT PIDs and IN packets the host does not acknowledge; a design that commits these anyway moves the counts too early. Short packets, the last packet, size writes while enabled and disables in idle each show whether enable clears at the right time and which flag pulses with it.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int FIFO_W = 4;
  localparam int MPS_W  = 11;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA0 = 3'd4,
    RSP_DATA1 = 3'd5
  } rsp_e;

  typedef enum logic [1:0] {
    XT_ISO   = 2'd0,
    XT_BULK  = 2'd1,
    XT_INTR  = 2'd2,
    XT_BULKX = 2'd3
  } xtype_e;

  typedef struct packed {
    logic              active;
    xtype_e            xtype;
    logic              odd_frame;
    logic              force_nak;
    logic              force_stall;
    logic              snoop;
    logic [FIFO_W-1:0] fifo;
    logic [MPS_W-1:0]  mps;
  } ep_cfg_t;
endpackage

// File: rtl/usb_ep_cfg_regs.sv
module usb_ep_cfg_regs
  import usb_ep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output ep_cfg_t     cfg
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en && !wr_sel) begin
      cfg.active      <= wr_data[2];
      cfg.xtype       <= xtype_e'(wr_data[4:3]);
      cfg.odd_frame   <= wr_data[7];
      cfg.force_nak   <= wr_data[8];
      cfg.force_stall <= wr_data[9];
      cfg.snoop       <= wr_data[10];
      cfg.fifo        <= wr_data[11 +: FIFO_W];
      cfg.mps         <= wr_data[16 +: MPS_W];
    end
  end
endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
#(
  parameter int BYTES_W = 19,
  parameter int LEN_W   = 11
) (
  input  ep_cfg_t            cfg,
  input  logic               en,
  input  logic               toggle,
  input  logic               tok_is_in,
  input  logic               rx_data1,
  input  logic               rx_crc_ok,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               fifo_ok,
  input  logic               frame_odd,
  input  logic [BYTES_W-1:0] bytes,
  output rsp_e               code,
  output logic [LEN_W-1:0]   len,
  output logic               commit,
  output logic               await_hs
);
  logic               is_iso, par_ok;
  logic [BYTES_W-1:0] mps_ext, in_full;
  logic [LEN_W-1:0]   in_len;
  logic               unused_fifo;

  assign unused_fifo = ^cfg.fifo;
  assign is_iso  = (cfg.xtype == XT_ISO);
  assign par_ok  = (cfg.odd_frame == frame_odd);
  assign mps_ext = BYTES_W'(cfg.mps);
  assign in_full = (bytes < mps_ext) ? bytes : mps_ext;
  assign in_len  = LEN_W'(in_full);

  always_comb begin
    code     = RSP_NONE;
    len      = '0;
    commit   = 1'b0;
    await_hs = 1'b0;
    if (!cfg.active) begin
      code = RSP_NONE;
    end else if (!tok_is_in && !rx_crc_ok && !cfg.snoop) begin
      code = RSP_NONE;
    end else if (cfg.force_stall) begin
      code = RSP_STALL;
    end else if (cfg.force_nak) begin
      code = RSP_NAK;
    end else if (is_iso) begin
      if (en && par_ok && fifo_ok) begin
        commit = 1'b1;
        if (tok_is_in) begin
          code = RSP_DATA0;
          len  = in_len;
        end else begin
          len  = rx_len;
        end
      end
    end else if (!en || !fifo_ok) begin
      code = RSP_NAK;
    end else if (tok_is_in) begin
      code     = toggle ? RSP_DATA1 : RSP_DATA0;
      len      = in_len;
      await_hs = 1'b1;
    end else begin
      code = RSP_ACK;
      if (rx_data1 == toggle) begin
        commit = 1'b1;
        len    = rx_len;
      end
    end
  end
endmodule

// File: rtl/usb_ep_xfer.sv
module usb_ep_xfer
  import usb_ep_pkg::*;
#(
  parameter int BYTES_W = 19,
  parameter int PKT_W   = 10,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               is_iso,
  input  logic [MPS_W-1:0]   mps,
  input  logic               tok_fire,
  input  logic               commit,
  input  logic               await_hs,
  input  logic [LEN_W-1:0]   dec_len,
  input  logic               hs_valid,
  input  logic               hs_ack,
  output logic               ep_en,
  output logic [BYTES_W-1:0] bytes,
  output logic [PKT_W-1:0]   pkts,
  output logic               toggle,
  output logic               awaiting,
  output logic               xfer_done,
  output logic               ep_disabled
);
  logic [LEN_W-1:0]   pend_len, clen;
  logic [BYTES_W-1:0] sub;
  logic [PKT_W-1:0]   pkts_nxt;
  logic               hs_ok, hs_end, do_commit, finish, ctrl_wr, size_wr, wr_iso, dis_req;
  logic               unused_wr;

  assign unused_wr = ^wr_data;
  assign ctrl_wr   = wr_en && !wr_sel;
  assign size_wr   = wr_en && wr_sel;
  assign wr_iso    = (wr_data[4:3] == 2'b00);
  assign hs_end    = awaiting && hs_valid;
  assign hs_ok     = hs_end && hs_ack;
  assign do_commit = (tok_fire && commit) || hs_ok;
  assign clen      = tok_fire ? dec_len : pend_len;
  assign sub       = (BYTES_W'(clen) > bytes) ? bytes : BYTES_W'(clen);
  assign pkts_nxt  = (pkts == '0) ? '0 : pkts - PKT_W'(1);
  assign finish    = do_commit && ((pkts_nxt == '0) || (clen < LEN_W'(mps)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_en       <= 1'b0;
      bytes       <= '0;
      pkts        <= '0;
      toggle      <= 1'b0;
      awaiting    <= 1'b0;
      pend_len    <= '0;
      dis_req     <= 1'b0;
      xfer_done   <= 1'b0;
      ep_disabled <= 1'b0;
    end else begin
      xfer_done   <= finish;
      ep_disabled <= 1'b0;
      if (size_wr && !ep_en) begin
        bytes <= wr_data[BYTES_W-1:0];
        pkts  <= wr_data[BYTES_W +: PKT_W];
      end
      if (ctrl_wr && wr_data[0]) ep_en <= 1'b1;
      if (ctrl_wr && wr_data[6] && !wr_iso) toggle <= wr_data[5];
      if (ctrl_wr && wr_data[1] && ep_en) dis_req <= 1'b1;
      if (tok_fire && await_hs) begin
        awaiting <= 1'b1;
        pend_len <= dec_len;
      end
      if (hs_end) awaiting <= 1'b0;
      if (do_commit) begin
        bytes <= bytes - sub;
        pkts  <= pkts_nxt;
        if (!is_iso) toggle <= ~toggle;
        if (finish) ep_en <= 1'b0;
      end
      if (dis_req && !awaiting && !tok_fire) begin
        dis_req <= 1'b0;
        if (ep_en) begin
          ep_en       <= 1'b0;
          ep_disabled <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usb_ep_xfer_ctrl.sv
module usb_ep_xfer_ctrl
  import usb_ep_pkg::*;
#(
  parameter int BYTES_W = 19,
  parameter int PKT_W   = 10,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               tok_valid,
  output logic               tok_ready,
  input  logic               tok_is_in,
  input  logic               rx_data1,
  input  logic               rx_crc_ok,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               fifo_ok,
  input  logic               frame_odd,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [2:0]         resp_code,
  output logic [LEN_W-1:0]   resp_len,
  input  logic               hs_valid,
  input  logic               hs_ack,
  output logic               ep_enabled,
  output logic [BYTES_W-1:0] xfer_bytes,
  output logic [PKT_W-1:0]   xfer_pkts,
  output logic               data_toggle,
  output logic [FIFO_W-1:0]  tx_fifo_num,
  output logic [MPS_W-1:0]   max_pkt,
  output logic               xfer_done,
  output logic               ep_disabled
);
  ep_cfg_t          cfg;
  rsp_e             dec_code, code_q;
  logic [LEN_W-1:0] dec_len, len_q;
  logic             dec_commit, dec_await, awaiting, tok_fire, is_iso, valid_q;

  assign is_iso    = (cfg.xtype == XT_ISO);
  assign tok_ready = !valid_q && !awaiting;
  assign tok_fire  = tok_valid && tok_ready;

  usb_ep_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg(cfg)
  );

  usb_ep_decide #(.BYTES_W(BYTES_W), .LEN_W(LEN_W)) u_dec (
    .cfg(cfg), .en(ep_enabled), .toggle(data_toggle), .tok_is_in(tok_is_in),
    .rx_data1(rx_data1), .rx_crc_ok(rx_crc_ok), .rx_len(rx_len),
    .fifo_ok(fifo_ok), .frame_odd(frame_odd), .bytes(xfer_bytes),
    .code(dec_code), .len(dec_len), .commit(dec_commit), .await_hs(dec_await)
  );

  usb_ep_xfer #(.BYTES_W(BYTES_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .is_iso(is_iso), .mps(cfg.mps), .tok_fire(tok_fire), .commit(dec_commit),
    .await_hs(dec_await), .dec_len(dec_len), .hs_valid(hs_valid), .hs_ack(hs_ack),
    .ep_en(ep_enabled), .bytes(xfer_bytes), .pkts(xfer_pkts), .toggle(data_toggle),
    .awaiting(awaiting), .xfer_done(xfer_done), .ep_disabled(ep_disabled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= RSP_NONE;
      len_q   <= '0;
    end else if (tok_fire) begin
      valid_q <= 1'b1;
      code_q  <= dec_code;
      len_q   <= dec_len;
    end else if (resp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign resp_valid  = valid_q;
  assign resp_code   = code_q;
  assign resp_len    = len_q;
  assign tx_fifo_num = cfg.fifo;
  assign max_pkt     = cfg.mps;
endmodule

// File: rtl/usb_ep_xfer_ctrl_chk.sv
module usb_ep_xfer_ctrl_chk #(
  parameter int BYTES_W = 19,
  parameter int PKT_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tok_valid,
  input logic               tok_ready,
  input logic               tok_is_in,
  input logic               rx_crc_ok,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic [2:0]         resp_code,
  input logic               hs_valid,
  input logic               ep_enabled,
  input logic [BYTES_W-1:0] xfer_bytes,
  input logic [PKT_W-1:0]   xfer_pkts,
  input logic               xfer_done,
  input logic               ep_disabled,
  input logic               cfg_active,
  input logic               cfg_stall,
  input logic               cfg_snoop,
  input logic               is_iso
);
  logic fire;
  assign fire = tok_valid && tok_ready;

  assert_stall_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_active && cfg_stall && (tok_is_in || rx_crc_ok || cfg_snoop))
    |=> (resp_valid && resp_code == 3'd3));

  assert_iso_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_iso) |=> (resp_code != 3'd1));

  assert_size_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_enabled && !fire && !hs_valid) |=> ($stable(xfer_bytes) && $stable(xfer_pkts)));

  assert_done_clears_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !ep_enabled);

  assert_disabled_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ep_disabled |-> (!ep_enabled && !xfer_done));

  assert_resp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_code)));

  assert_one_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !tok_ready);
endmodule

bind usb_ep_xfer_ctrl usb_ep_xfer_ctrl_chk #(.BYTES_W(BYTES_W), .PKT_W(PKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
  .tok_is_in(tok_is_in), .rx_crc_ok(rx_crc_ok), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_code(resp_code), .hs_valid(hs_valid),
  .ep_enabled(ep_enabled), .xfer_bytes(xfer_bytes), .xfer_pkts(xfer_pkts),
  .xfer_done(xfer_done), .ep_disabled(ep_disabled), .cfg_active(cfg.active),
  .cfg_stall(cfg.force_stall), .cfg_snoop(cfg.snoop), .is_iso(is_iso)
);

// File: tb/usb_ep_xfer_ctrl_bench.sv
module usb_ep_xfer_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic        tok_valid = 0, tok_ready, tok_is_in = 0, rx_data1 = 0, rx_crc_ok = 1;
  logic [10:0] rx_len = 0;
  logic        fifo_ok = 1, frame_odd = 0, resp_valid, resp_ready = 1;
  logic [2:0]  resp_code;
  logic [10:0] resp_len;
  logic        hs_valid = 0, hs_ack = 0, ep_enabled, data_toggle, xfer_done, ep_disabled;
  logic [18:0] xfer_bytes;
  logic [9:0]  xfer_pkts;
  logic [3:0]  tx_fifo_num;
  logic [10:0] max_pkt;

  always #4 clk = ~clk;

  usb_ep_xfer_ctrl u_usb_ep_xfer_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  bit m_en = 0, m_tog = 0;
  int m_bytes = 0, m_pkts = 0;
  bit c_act, c_odd, c_nak, c_stall, c_snoop;
  int c_type, c_fifo, c_mps;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit en, bit dis, bit tval, bit tload);
    logic [10:0] mp = c_mps[10:0];
    logic [3:0]  ff = c_fifo[3:0];
    logic [1:0]  ty = c_type[1:0];
    return {5'b0, mp, 1'b0, ff, c_snoop, c_stall, c_nak, c_odd, tload, tval, ty, c_act, dis, en};
  endfunction

  task automatic write(input bit sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_ctrl(input bit en, input bit tval, input bit tload);
    write(0, ctrl_word(en, 0, tval, tload));
    if (tload && c_type != 0) m_tog = tval;
    if (en) m_en = 1;
  endtask

  task automatic wr_size(input int b, input int p);
    logic [18:0] bb = b[18:0];
    logic [9:0]  pp = p[9:0];
    write(1, {3'b0, pp, bb});
    if (!m_en) begin m_bytes = b; m_pkts = p; end
  endtask

  task automatic do_disable();
    bit was = m_en;
    write(0, ctrl_word(0, 1, 0, 0));
    @(negedge clk);
    chk("R11 disabled pulse", ep_disabled, was);
    chk("R11 enable cleared", ep_enabled, 0);
    m_en = 0;
  endtask

  task automatic check_state(input string tag, input bit done);
    chk({tag, " R10 done pulse"}, xfer_done, done);
    chk({tag, " R10 enable"}, ep_enabled, m_en);
    chk({tag, " R10 bytes"}, xfer_bytes, m_bytes);
    chk({tag, " R10 pkts"}, xfer_pkts, m_pkts);
    chk({tag, " R8 toggle"}, data_toggle, m_tog);
  endtask

  task automatic token(input bit is_in, input bit d1, input bit crc, input int len,
                       input bit fok, input bit fodd, input bit ack);
    int e_code = 0, e_len = 0, clen = 0, in_len, sub;
    bit e_commit = 0, e_await = 0, is_iso, done = 0;
    string tag = "R3";
    is_iso = (c_type == 0);
    in_len = (m_bytes < c_mps) ? m_bytes : c_mps;
    if (!c_act) tag = "R3";
    else if (!is_in && !crc && !c_snoop) tag = "R3";
    else if (c_stall) begin e_code = 3; tag = "R4"; end
    else if (c_nak) begin e_code = 2; tag = "R5"; end
    else if (is_iso) begin
      tag = "R6";
      if (m_en && fodd == c_odd && fok) begin
        e_commit = 1;
        if (is_in) begin e_code = 4; clen = in_len; e_len = in_len; end
        else clen = len;
      end
    end
    else if (!m_en || !fok) begin e_code = 2; tag = "R5"; end
    else if (is_in) begin
      e_code = m_tog ? 5 : 4; e_len = in_len; clen = in_len; e_await = 1; tag = "R7";
    end else begin
      e_code = 1; tag = "R8";
      if (d1 == m_tog) begin e_commit = 1; clen = len; end
    end
    @(negedge clk);
    chk("R12 tok_ready idle", tok_ready, 1);
    tok_valid = 1; tok_is_in = is_in; rx_data1 = d1; rx_crc_ok = crc;
    rx_len = len[10:0]; fifo_ok = fok; frame_odd = fodd;
    @(negedge clk);
    tok_valid = 0;
    chk("R12 resp_valid", resp_valid, 1);
    chk({tag, " resp_code"}, resp_code, e_code);
    if (e_code >= 4) chk({tag, " resp_len"}, resp_len, e_len);
    if (e_await) begin
      chk("R12 tok_ready while awaiting", tok_ready, 0);
      hs_valid = 1; hs_ack = ack;
      @(negedge clk);
      hs_valid = 0;
      if (ack) e_commit = 1;
    end
    if (e_commit) begin
      sub = (clen > m_bytes) ? m_bytes : clen;
      m_bytes -= sub;
      m_pkts = (m_pkts == 0) ? 0 : m_pkts - 1;
      if (!is_iso) m_tog = ~m_tog;
      if (m_pkts == 0 || clen < c_mps) begin m_en = 0; done = 1; end
    end
    check_state(tag, done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tok_ready", tok_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    check_state("R1 reset", 0);
    chk("R1 disabled flag", ep_disabled, 0);

    // R2: field layout reaches the outputs; bulk endpoint
    c_act = 1; c_type = 1; c_odd = 0; c_nak = 0; c_stall = 0; c_snoop = 0;
    c_fifo = 9; c_mps = 64;
    wr_ctrl(0, 1, 1);
    chk("R2 tx_fifo_num", tx_fifo_num, 9);
    chk("R2 max_pkt", max_pkt, 64);
    chk("R8 toggle load", data_toggle, 1);

    // R9: size lock while enabled
    wr_size(200, 4);
    wr_ctrl(1, 0, 0);
    wr_size(17, 2);
    chk("R9 bytes locked", xfer_bytes, 200);
    chk("R9 pkts locked", xfer_pkts, 4);
    token(1, 0, 1, 0, 1, 0, 1);   // R7 DATA1 full packet acked
    token(1, 0, 1, 0, 1, 0, 0);   // R7 not acked: no change
    token(0, 1, 1, 10, 1, 0, 0);  // R8 pid mismatch dropped
    token(0, 0, 1, 10, 1, 0, 0);  // R10 short OUT ends transfer
    chk("R10 ended", ep_enabled, 0);

    // R12: back-pressure with forced NAK
    c_nak = 1; wr_ctrl(0, 0, 0);
    @(negedge clk); resp_ready = 0; tok_valid = 1; tok_is_in = 1;
    @(negedge clk); tok_valid = 0;
    repeat (3) @(negedge clk);
    chk("R12 held valid", resp_valid, 1);
    chk("R5 held NAK", resp_code, 2);
    chk("R12 no new token", tok_ready, 0);
    resp_ready = 1;
    @(negedge clk);
    chk("R12 released", resp_valid, 0);

    // R4: stall beats nak
    c_stall = 1; wr_ctrl(0, 0, 0);
    token(1, 0, 1, 0, 1, 0, 1);
    // R8: toggle load ignored for isochronous
    c_stall = 0; c_nak = 0; c_type = 0; m_tog = data_toggle;
    wr_ctrl(0, ~m_tog, 1);
    chk("R8 iso toggle load ignored", data_toggle, m_tog);
    // R6 parity mismatch then match
    wr_size(100, 3); wr_ctrl(1, 0, 0);
    token(0, 0, 1, 20, 1, 1, 0);
    token(0, 0, 1, 20, 1, 0, 0);
    // R3 snoop accepts bad CRC
    c_type = 2; c_snoop = 1; c_mps = 16; wr_ctrl(0, 0, 0);
    m_en = 0; do_disable();
    wr_size(40, 3); wr_ctrl(1, 0, 0);
    token(0, m_tog, 0, 16, 1, 0, 0);
    // R11 disable in idle
    do_disable();

    for (int it = 0; it < 200; it++) begin
      c_type = $urandom_range(0, 3);
      c_act = ($urandom % 16) != 0;
      c_stall = ($urandom % 8) == 0;
      c_nak = ($urandom % 8) == 0;
      c_snoop = ($urandom % 4) == 0;
      c_odd = $urandom % 2;
      c_fifo = $urandom % 16;
      case ($urandom % 3) 0: c_mps = 8; 1: c_mps = 16; default: c_mps = 64; endcase
      wr_ctrl(0, $urandom % 2, $urandom % 2);
      wr_size($urandom_range(0, 300), $urandom_range(1, 8));
      wr_ctrl(1, 0, 0);
      for (int t = 0; t < 10; t++) begin
        bit in_t = $urandom % 2;
        bit d1 = (($urandom % 4) != 0) ? m_tog : ~m_tog;
        int ln = (($urandom % 2) != 0) ? c_mps : $urandom_range(0, c_mps);
        token(in_t, d1, ($urandom % 8) != 0, ln, ($urandom % 8) != 0,
              (($urandom % 4) != 0) ? c_odd : ~c_odd, ($urandom % 4) != 0);
      end
      if (m_en || ($urandom % 4) == 0) do_disable();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule